// File: doc/BRIEF.md
# Six-Mode Barrel Shift and Rotate Unit

This block shifts or rotates a data word by an amount given in a few bits. It supports six operations: logical shifts in both directions, arithmetic shifts in both directions and rotations in both directions. It is built as a logarithmic barrel. Each stage moves the word by a power of two, and one bit of the amount enables that stage. The delay through the datapath therefore grows with the log of the width, not with the width.

The arithmetic left shift is not the usual one. Instead of zeros, it copies the least significant bit of the input into every vacated low position. The arithmetic right shift copies the most significant bit into the vacated high positions. The two remaining operation codes pass the data through untouched.

A parameter selects whether an output register with a valid flag is included. When it is included, a result appears one clock after it is requested. While no request arrives, the register keeps its last result.

Top module: `shr_unit`

## Requirements
- R1: Operation code 000 is the logical left shift. Bits move toward the MSB and the vacated low positions fill with 0. Example: 10010101 by 2 gives 01010100.
- R2: Operation code 001 is the logical right shift. Bits move toward the LSB and the vacated high positions fill with 0. Example: 10010101 by 2 gives 00100101.
- R3: Operation code 010 is the arithmetic left shift. The vacated low positions fill with the input's bit 0. Example: 10010101 by 2 gives 01010111.
- R4: Operation code 011 is the arithmetic right shift. The vacated high positions fill with the input's top bit. Example: 10010101 by 2 gives 11100101.
- R5: Operation code 100 is the left rotation. Bits leaving the MSB end re-enter at the LSB end. Example: 10010101 by 2 gives 01010110.
- R6: Operation code 101 is the right rotation. Bits leaving the LSB end re-enter at the MSB end. Example: 10010101 by 2 gives 01100101.
- R7: Operation codes 110 and 111 return the data unchanged for every amount.
- R8: An amount of 0 returns the data unchanged for every operation code.
- R9: With the output register present, `out_valid` is high exactly one clock after a cycle in which `in_valid` is high. The result in `dout` belongs to that request.
- R10: In a cycle with `in_valid` low, `dout` keeps its previous value.
- R11: While `rst_n` is low, `out_valid` and `dout` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe: load a new result |
| op | input | 3 | Operation code |
| amt | input | $clog2(W) | Shift or rotate distance |
| din | input | W | Operand |
| out_valid | output | 1 | Result in `dout` is new this cycle |
| dout | output | W | Shifted or rotated result |

## Verification
The bench uses the default parameters: an 8-bit word, a 3-bit amount and the output register present. At this size, every pairing of the eight codes with the eight amounts can be applied in full to each data pattern. The patterns include all-zeros, all-ones, both alternating patterns, single-bit words and a pseudo-random sweep. This exercises each fill rule at its extremes: the only-one-bit-survives case at amount 7, the case where the fill bit equals the shifted-out bits, and wrap-around through all three stages together. Gaps in the request stream test the hold behaviour.

// File: rtl/shr_pkg.sv
package shr_pkg;

  typedef enum logic [2:0] {
    OP_LSL  = 3'b000,
    OP_LSR  = 3'b001,
    OP_ASL  = 3'b010,
    OP_ASR  = 3'b011,
    OP_ROL  = 3'b100,
    OP_ROR  = 3'b101,
    OP_THR6 = 3'b110,
    OP_THR7 = 3'b111
  } shr_op_e;

  // Per-request steering shared by every barrel stage
  typedef struct packed {
    logic to_left;  // direction of movement
    logic wrap;     // rotate: re-insert departing bits
    logic fill;     // value inserted when not wrapping
    logic active;   // stages may move data at all
  } shr_ctrl_t;

endpackage

// File: rtl/shr_decode.sv
module shr_decode
  import shr_pkg::*;
(
  input  logic [2:0] op,
  input  logic       lsb,
  input  logic       msb,
  output shr_ctrl_t  ctrl
);

  always_comb begin
    ctrl = '{to_left: 1'b1, wrap: 1'b0, fill: 1'b0, active: 1'b1};
    unique case (shr_op_e'(op))
      OP_LSL:  ctrl = '{to_left: 1'b1, wrap: 1'b0, fill: 1'b0, active: 1'b1};
      OP_LSR:  ctrl = '{to_left: 1'b0, wrap: 1'b0, fill: 1'b0, active: 1'b1};
      OP_ASL:  ctrl = '{to_left: 1'b1, wrap: 1'b0, fill: lsb,  active: 1'b1};
      OP_ASR:  ctrl = '{to_left: 1'b0, wrap: 1'b0, fill: msb,  active: 1'b1};
      OP_ROL:  ctrl = '{to_left: 1'b1, wrap: 1'b1, fill: 1'b0, active: 1'b1};
      OP_ROR:  ctrl = '{to_left: 1'b0, wrap: 1'b1, fill: 1'b0, active: 1'b1};
      OP_THR6,
      OP_THR7: ctrl = '{to_left: 1'b1, wrap: 1'b0, fill: 1'b0, active: 1'b0};
      default: ctrl = '{to_left: 1'b1, wrap: 1'b0, fill: 1'b0, active: 1'b0};
    endcase
  end

endmodule

// File: rtl/shr_stage.sv
// One barrel level: moves the word by a fixed distance SH when sel is set.
module shr_stage #(
  parameter int W  = 8,
  parameter int SH = 1
) (
  input  logic         sel,
  input  logic         to_left,
  input  logic         wrap,
  input  logic         fill,
  input  logic [W-1:0] x,
  output logic [W-1:0] y
);

  logic [W-1:0] moved_l;
  logic [W-1:0] moved_r;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i >= SH) begin : g_l_in
      assign moved_l[i] = x[i-SH];
    end else begin : g_l_edge
      assign moved_l[i] = wrap ? x[i-SH+W] : fill;
    end
    if (i + SH < W) begin : g_r_in
      assign moved_r[i] = x[i+SH];
    end else begin : g_r_edge
      assign moved_r[i] = wrap ? x[i+SH-W] : fill;
    end
  end

  always_comb begin
    if (!sel)        y = x;
    else if (to_left) y = moved_l;
    else             y = moved_r;
  end

endmodule

// File: rtl/shr_outreg.sv
module shr_outreg #(
  parameter int W       = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] res,
  output logic         out_valid,
  output logic [W-1:0] dout
);

  if (REG_OUT) begin : g_reg
    logic [W-1:0] dout_d, dout_q;
    logic         vld_d, vld_q;

    always_comb begin
      vld_d  = load;
      dout_d = dout_q;
      if (load) dout_d = res;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q  <= 1'b0;
        dout_q <= '0;
      end else begin
        vld_q  <= vld_d;
        dout_q <= dout_d;
      end
    end

    assign out_valid = vld_q;
    assign dout      = dout_q;
  end else begin : g_comb
    assign out_valid = load;
    assign dout      = res;
  end

endmodule

// File: rtl/shr_unit.sv
module shr_unit
  import shr_pkg::*;
#(
  parameter int W       = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [2:0]           op,
  input  logic [$clog2(W)-1:0] amt,
  input  logic [W-1:0]         din,
  output logic                 out_valid,
  output logic [W-1:0]         dout
);

  localparam int AW = $clog2(W);

  shr_ctrl_t    ctrl;
  logic [W-1:0] lvl [AW+1];

  shr_decode u_dec (
    .op   (op),
    .lsb  (din[0]),
    .msb  (din[W-1]),
    .ctrl (ctrl)
  );

  assign lvl[0] = din;

  for (genvar k = 0; k < AW; k++) begin : g_stage
    shr_stage #(.W(W), .SH(1 << k)) u_stg (
      .sel     (amt[k] & ctrl.active),
      .to_left (ctrl.to_left),
      .wrap    (ctrl.wrap),
      .fill    (ctrl.fill),
      .x       (lvl[k]),
      .y       (lvl[k+1])
    );
  end

  shr_outreg #(.W(W), .REG_OUT(REG_OUT)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (in_valid),
    .res       (lvl[AW]),
    .out_valid (out_valid),
    .dout      (dout)
  );

endmodule

// File: rtl/shr_unit_chk.sv
module shr_unit_chk #(
  parameter int W = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic [2:0]           op,
  input logic [$clog2(W)-1:0] amt,
  input logic [W-1:0]         din,
  input logic                 out_valid,
  input logic [W-1:0]         dout
);

  assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_valid_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(dout));

  assert_zero_amount_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && amt == '0) |=> dout == $past(din));

  assert_passthrough_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op[2:1] == 2'b11) |=> dout == $past(din));

  assert_rotl_bits_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 3'b100) |=> $countones(dout) == $countones($past(din)));

  assert_rotr_bits_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 3'b101) |=> $countones(dout) == $countones($past(din)));

  assert_lsl_far_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 3'b000 && amt == '1) |=> $countones(dout) <= 1);

  assert_lsr_far_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 3'b001 && amt == '1) |=> $countones(dout) <= 1);

  assert_asl_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 3'b010 && amt != '0) |=> dout[0] == $past(din[0]));

  assert_asr_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 3'b011) |=> dout[W-1] == $past(din[W-1]));

  always @(negedge clk) begin
    if (!rst_n) begin
      assert_reset_clear_R11: assert (!out_valid && dout == '0);
    end
  end

endmodule

bind shr_unit shr_unit_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .op        (op),
  .amt       (amt),
  .din       (din),
  .out_valid (out_valid),
  .dout      (dout)
);

// File: tb/sim_shr_unit.sv
`timescale 1ns/1ps
module sim_shr_unit;

  localparam int W  = 8;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic [2:0]    op;
  logic [AW-1:0] amt;
  logic [W-1:0]  din;
  logic          out_valid;
  logic [W-1:0]  dout;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [W-1:0] exp_d;
  logic         exp_v;
  string        exp_tag;
  bit           have_exp = 0;

  always #2.5 clk = ~clk;

  shr_unit #(.W(W), .REG_OUT(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
    .amt(amt), .din(din), .out_valid(out_valid), .dout(dout)
  );

  function automatic int model(input int o, input int a, input int d);
    int m, r;
    m = (1 << W) - 1;
    case (o)
      0: r = (d << a) & m;
      1: r = d >> a;
      2: r = ((d << a) | ((d & 1) != 0 ? (1 << a) - 1 : 0)) & m;
      3: r = (d >> a) | ((d >> (W-1)) != 0 ? (m & ~(m >> a)) : 0);
      4: r = ((d << a) | (d >> (W - a))) & m;
      5: r = ((d >> a) | (d << (W - a))) & m;
      default: r = d;
    endcase
    return r;
  endfunction

  function automatic string tag_of(input int o, input int a);
    if (o >= 6) return "R7";
    if (a == 0) return "R8";
    case (o)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic v, input int o, input int a, input int d);
    @(negedge clk);
    if (have_exp) begin
      check("R9", int'(out_valid), int'(exp_v));
      check(exp_tag, int'(dout), int'(exp_d));
    end
    in_valid = v;
    op  = o[2:0];
    amt = a[AW-1:0];
    din = d[W-1:0];
    exp_v = v;
    if (v) begin
      exp_d   = model(o, a, d) & 8'hFF;
      exp_tag = tag_of(o, a);
    end else begin
      exp_tag = "R10";
    end
    have_exp = 1;
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; op = '0; amt = '0; din = '0;
    repeat (3) @(negedge clk);
    check("R11", int'(out_valid), 0);
    check("R11", int'(dout), 0);
    rst_n = 1'b1;
    exp_d = '0;

    // stated example word by 2 in every mode (R1..R6)
    for (int o = 0; o < 6; o++) apply(1'b1, o, 2, 8'h95);

    // full sweep over codes and amounts for fixed patterns
    begin
      int pats [8] = '{8'h95, 8'hFF, 8'h00, 8'hAA, 8'h55, 8'h01, 8'h80, 8'h6C};
      for (int p = 0; p < 8; p++)
        for (int o = 0; o < 8; o++)
          for (int a = 0; a < 8; a++)
            apply(1'b1, o, a, pats[p]);
    end

    // pseudo-random words with idle gaps (R10)
    begin
      int lf = 8'h3B;
      for (int n = 0; n < 200; n++) begin
        lf = ((lf << 1) | (((lf >> 7) ^ (lf >> 5) ^ (lf >> 4) ^ (lf >> 3)) & 1)) & 8'hFF;
        apply(1'b1, n % 8, (n / 8) % 8, lf);
        if (n % 5 == 0) begin
          apply(1'b0, 3, 5, 8'h5A);
          apply(1'b0, 0, 1, 8'hFF);
        end
      end
    end

    apply(1'b0, 0, 0, 0);
    @(negedge clk);
    check("R9", int'(out_valid), 0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R9 watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule